// File: doc/BRIEF.md
# Timer Register Burst Window

This unit sits inside a 32-bit timer peripheral. It lets a DMA engine fetch a run of consecutive timer registers through a single fixed read address. Software programs a start word index and a transfer count, then enables one or more of seven timer event sources. When an enabled event fires, the unit raises a DMA request. Each read of the window address returns the timer register at the start index plus the current step, then moves one step on. After the last step the request drops and the step counter goes back to zero.

The timer's counters and capture logic are outside the unit. Event sources appear as single-cycle pulses. The timer register file is reached through a word-index output and a read-data input. An event that arrives during a running burst is held and starts a fresh burst as soon as the current one completes. Writing a zero configuration, or leaving no source enabled, cancels the burst and any held event.

Top module: `timer_burst_window`

## Requirements
- R1: After reset, `dma_req` is low and the burst configuration (0x48), source enable (0x0C) and event flag (0x10) registers all read zero.
- R2: The burst configuration register at byte offset 0x48 holds the start word index in bits 4:0 and the transfer count minus one in bits 12:8. It reads back only those fields; all other bits read zero.
- R3: The source enable register at 0x0C uses bit 8 for update, bits 9..12 for capture/compare 1..4, bit 13 for commutation and bit 14 for trigger. It reads back only bits 14:8. On the `evt_pulse` port, bits 0..6 are capture/compare 1..4, update, trigger and commutation.
- R4: An event pulse whose source is enabled raises `dma_req` on the next clock edge. A pulse whose source is disabled leaves `dma_req` low.
- R5: During a burst, the k-th read (k from 0) of the window at 0x4C returns the register-file word at start index + k, and `rf_idx` shows that index.
- R6: After count+1 window reads, `dma_req` is low on the next edge and the step index is back at zero.
- R7: An enabled event during a running burst is held. When the burst ends, `dma_req` stays high and a new burst begins at the start index.
- R8: Two writes abort: a write of zero to both configuration fields, or a write to the enable register that leaves no source enabled. Either one drops `dma_req` on the next edge, resets the step index and discards a held event.
- R9: The event flag register at 0x10 holds one bit per source in `evt_pulse` order (bits 6:0). A pulse sets its bit whether or not the source is enabled. A write clears every flag written as 0 and keeps those written as 1.
- R10: A window read while no burst is running returns the word at the start index and does not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe; a read of 0x4C is one window transfer |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd_en` |
| evt_pulse | input | 7 | Timer event pulses, one bit per source |
| rf_idx | output | ADDR_W-2 | Word index into the timer register file |
| rf_data | input | 32 | Register-file word at `rf_idx` |
| dma_req | output | 1 | DMA request, high while a burst is running |

## Verification
The assertions check the handshake edges on every cycle:
- an enabled event always raises the request;
- the request never appears without an event;
- an abort always drops it;
- the register-file index steps by exactly one on each mid-burst read, stays at or above the start index, and returns to the start after the final read.

Only the bench scenarios can show that the returned data matches the right register for every start and length, and that each source maps to its own enable bit. They also cover the held event producing a second burst with the correct content, and the flag register's clear-on-zero writes.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int DATA_W   = 32;
  localparam int NSRC     = 7;
  localparam int BASE_W   = 5;
  localparam int CNT_W    = 5;
  localparam int CTRL_OFF = 'h48;
  localparam int WIN_OFF  = 'h4C;
  localparam int EN_OFF   = 'h0C;
  localparam int FLAG_OFF = 'h10;
  localparam int EN_LSB   = 8;
  localparam int EN_W     = 7;

  // source index -> bit position in the enable register
  function automatic int src_en_pos(input int s);
    case (s)
      0, 1, 2, 3: return 9 + s;
      4:          return 8;
      5:          return 14;
      default:    return 13;
    endcase
  endfunction

  typedef struct packed {
    logic [CNT_W-1:0]  last;
    logic [BASE_W-1:0] base;
  } burst_cfg_t;
endpackage

// File: rtl/tbw_regs.sv
module tbw_regs
  import tbw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NSRC-1:0]         evt,
  input  logic [DATA_W-1:0]       win_data,
  output burst_cfg_t              cfg,
  output logic [NSRC-1:0]         src_en,
  output logic [DATA_W-1:0]       rdata,
  output logic                    abort,
  output logic                    win_rd
);
  logic sel_ctrl, sel_en, sel_flag, sel_win;
  burst_cfg_t       cfg_q, cfg_n;
  logic [EN_W-1:0]  en_q, en_n;
  logic [NSRC-1:0]  flags_q, flags_n;
  logic             cfg_ld, en_ld;
  logic             unused_wbits;

  assign sel_ctrl = (addr == ADDR_W'(CTRL_OFF));
  assign sel_en   = (addr == ADDR_W'(EN_OFF));
  assign sel_flag = (addr == ADDR_W'(FLAG_OFF));
  assign sel_win  = (addr == ADDR_W'(WIN_OFF));
  assign win_rd   = rd_en && sel_win;
  assign unused_wbits = ^{wdata[31:15], wdata[7]};

  assign cfg_ld = wr_en && sel_ctrl;
  assign en_ld  = wr_en && sel_en;

  always_comb begin
    cfg_n   = cfg_q;
    en_n    = en_q;
    flags_n = flags_q | evt;
    if (cfg_ld) cfg_n = '{last: wdata[12:8], base: wdata[4:0]};
    if (en_ld)  en_n  = wdata[EN_LSB+EN_W-1:EN_LSB];
    if (wr_en && sel_flag) flags_n = (flags_q & wdata[NSRC-1:0]) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= '0;
      flags_q <= '0;
    end else begin
      if (cfg_ld) cfg_q <= cfg_n;
      if (en_ld)  en_q  <= en_n;
      flags_q <= flags_n;
    end
  end

  assign abort = (cfg_ld && (wdata[12:8] == '0) && (wdata[4:0] == '0)) ||
                 (en_ld && (wdata[EN_LSB+EN_W-1:EN_LSB] == '0));

  for (genvar s = 0; s < NSRC; s++) begin : g_src_map
    localparam int P = src_en_pos(s) - EN_LSB;
    assign src_en[s] = en_q[P];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel_ctrl)      rdata = {19'b0, cfg_q.last, 3'b0, cfg_q.base};
      else if (sel_en)   rdata = {17'b0, en_q, 8'b0};
      else if (sel_flag) rdata = {{(DATA_W-NSRC){1'b0}}, flags_q};
      else if (sel_win)  rdata = win_data;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/tbw_seq.sv
module tbw_seq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             win_rd,
  input  logic             abort,
  input  logic [CNT_W-1:0] last,
  output logic             active,
  output logic [CNT_W-1:0] idx
);
  logic             act_q, act_n, pend_q, pend_n;
  logic [CNT_W-1:0] idx_q, idx_n;

  always_comb begin
    act_n  = act_q;
    pend_n = pend_q;
    idx_n  = idx_q;
    if (abort) begin
      act_n  = 1'b0;
      pend_n = 1'b0;
      idx_n  = '0;
    end else if (act_q) begin
      pend_n = pend_q | hit;
      if (win_rd) begin
        if (idx_q == last) begin
          idx_n  = '0;
          act_n  = pend_q | hit;
          pend_n = 1'b0;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
    end else if (hit) begin
      act_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      idx_q  <= idx_n;
    end
  end

  assign active = act_q;
  assign idx    = idx_q;
endmodule

// File: rtl/timer_burst_window.sv
module timer_burst_window
  import tbw_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [6:0]        evt_pulse,
  output logic [IDX_W-1:0]  rf_idx,
  input  logic [31:0]       rf_data,
  output logic              dma_req
);
  burst_cfg_t       cfg_w;
  logic [NSRC-1:0]  src_en_w;
  logic             abort_w, win_rd_w, src_hit;
  logic [CNT_W-1:0] step_w;
  logic [BASE_W-1:0] base_w;
  logic [CNT_W-1:0]  last_w;

  tbw_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .evt(evt_pulse), .win_data(rf_data),
    .cfg(cfg_w), .src_en(src_en_w), .rdata(bus_rdata), .abort(abort_w),
    .win_rd(win_rd_w)
  );

  assign src_hit = |(evt_pulse & src_en_w);
  assign base_w  = cfg_w.base;
  assign last_w  = cfg_w.last;

  tbw_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hit(src_hit), .win_rd(win_rd_w),
    .abort(abort_w), .last(last_w), .active(dma_req), .idx(step_w)
  );

  assign rf_idx = IDX_W'(base_w) + IDX_W'(step_w);
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_req,
  input logic             hit,
  input logic             abort,
  input logic             win_rd,
  input logic             wr_en,
  input logic [IDX_W-1:0] rf_idx,
  input logic [4:0]       base,
  input logic [4:0]       last
);
  logic [IDX_W-1:0] end_idx;
  assign end_idx = IDX_W'(base) + IDX_W'(last);

  assert_hit_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !abort) |=> dma_req);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && !hit) |=> !dma_req);
  assert_abort_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !dma_req);
  assert_idx_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_idx >= IDX_W'(base));
  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && win_rd && !abort && !wr_en && rf_idx != end_idx)
      |=> rf_idx == $past(rf_idx) + 1'b1);
  assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && win_rd && !abort && !wr_en && rf_idx == end_idx)
      |=> rf_idx == IDX_W'(base));
endmodule

bind timer_burst_window tbw_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .hit(src_hit),
  .abort(abort_w), .win_rd(win_rd_w), .wr_en(bus_wr_en),
  .rf_idx(rf_idx), .base(base_w), .last(last_w)
);

// File: tb/tb_timer_burst_window.sv
module tb_timer_burst_window;
  localparam int AW = 10;
  localparam int IW = AW - 2;
  localparam logic [AW-1:0] A_CTRL = 10'h048, A_WIN = 10'h04C,
                            A_EN = 10'h00C, A_FLAG = 10'h010;

  logic clk, rst_n, wr, rd;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata, rfd;
  logic [6:0] evt;
  logic [IW-1:0] ridx;
  logic req;
  int total, fails;

  timer_burst_window #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_rd_en(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .evt_pulse(evt), .rf_idx(ridx), .rf_data(rfd), .dma_req(req)
  );

  function automatic logic [31:0] rf_word(input int i);
    return 32'hC0DE_0000 + 32'(i) * 32'd7;
  endfunction
  assign rfd = rf_word(int'(ridx));

  function automatic int enpos(input int s);
    if (s < 4) return 9 + s;
    if (s == 4) return 8;
    if (s == 5) return 14;
    return 13;
  endfunction

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bread(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    total = 0; fails = 0;
    wr = 0; rd = 0; addr = '0; wdata = '0; evt = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(req == 1'b0, "R1 req", 32'(req), 0);
    bread(A_CTRL, d); chk(d == 0, "R1 ctrl", d, 0);
    bread(A_EN, d);   chk(d == 0, "R1 en", d, 0);
    bread(A_FLAG, d); chk(d == 0, "R1 flags", d, 0);

    // R2 configuration fields readback
    bwrite(A_CTRL, 32'hFFFF_FFFF);
    bread(A_CTRL, d); chk(d == 32'h1F1F, "R2 ctrl all ones", d, 32'h1F1F);
    bwrite(A_CTRL, 32'h0000_0A13);
    bread(A_CTRL, d); chk(d == 32'h0A13, "R2 ctrl fields", d, 32'h0A13);
    // R3 enable readback
    bwrite(A_EN, 32'hFFFF_FFFF);
    bread(A_EN, d); chk(d == 32'h7F00, "R3 en readback", d, 32'h7F00);
    bwrite(A_EN, 32'h0);

    // R3/R4 source-to-enable mapping sweep
    bwrite(A_CTRL, 32'h0000_0004);
    for (int s = 0; s < 7; s++) begin
      bwrite(A_EN, 32'(1) << enpos(s));
      for (int t = 0; t < 7; t++) begin
        pulse(7'(1) << t);
        chk(req == (t == s), $sformatf("R3 R4 src%0d en%0d", t, s),
            32'(req), 32'(t == s));
        if (req) begin
          bread(A_WIN, d);
          chk(d == rf_word(4), "R5 single", d, rf_word(4));
          chk(req == 1'b0, "R6 single done", 32'(req), 0);
        end
      end
    end

    // R5/R6 sweep over every start index and length
    bwrite(A_EN, 32'(1) << 9);
    for (int b = 0; b < 32; b++) begin
      for (int l = 0; l < 32; l++) begin
        bwrite(A_CTRL, 32'((l << 8) | b));
        pulse(7'h01);
        chk(req == 1'b1, "R4 sweep start", 32'(req), 1);
        for (int k = 0; k <= l; k++) begin
          bread(A_WIN, d);
          chk(d == rf_word(b + k), $sformatf("R5 b%0d l%0d k%0d", b, l, k),
              d, rf_word(b + k));
        end
        chk(req == 1'b0, "R6 sweep end", 32'(req), 0);
      end
    end

    // R10 idle window reads do not advance
    bwrite(A_CTRL, 32'h0000_0209);
    bread(A_WIN, d); chk(d == rf_word(9), "R10 idle 1", d, rf_word(9));
    bread(A_WIN, d); chk(d == rf_word(9), "R10 idle 2", d, rf_word(9));
    chk(req == 1'b0, "R10 req", 32'(req), 0);

    // R7 held event
    bwrite(A_EN, (32'(1) << 9) | (32'(1) << 8));
    bwrite(A_CTRL, 32'h0000_0202);
    pulse(7'h01);
    bread(A_WIN, d); chk(d == rf_word(2), "R7 a0", d, rf_word(2));
    pulse(7'h10);
    bread(A_WIN, d); chk(d == rf_word(3), "R7 a1", d, rf_word(3));
    bread(A_WIN, d); chk(d == rf_word(4), "R7 a2", d, rf_word(4));
    chk(req == 1'b1, "R7 second burst", 32'(req), 1);
    for (int k = 0; k < 3; k++) begin
      bread(A_WIN, d);
      chk(d == rf_word(2 + k), "R7 b", d, rf_word(2 + k));
    end
    chk(req == 1'b0, "R7 done", 32'(req), 0);

    // R8 abort by zero configuration, held event discarded
    pulse(7'h01);
    bread(A_WIN, d);
    pulse(7'h10);
    bwrite(A_CTRL, 32'h0);
    chk(req == 1'b0, "R8 ctrl abort", 32'(req), 0);
    bread(A_WIN, d); chk(d == rf_word(0), "R8 idle after abort", d, rf_word(0));
    chk(req == 1'b0, "R8 held discarded", 32'(req), 0);
    // R8 abort by disabling all sources
    bwrite(A_CTRL, 32'h0000_0306);
    pulse(7'h01);
    bread(A_WIN, d); chk(d == rf_word(6), "R5 pre abort", d, rf_word(6));
    bwrite(A_EN, 32'h0);
    chk(req == 1'b0, "R8 en abort", 32'(req), 0);
    bread(A_WIN, d); chk(d == rf_word(6), "R8 index reset", d, rf_word(6));

    // R9 flags
    bwrite(A_FLAG, 32'h0);
    bread(A_FLAG, d); chk(d == 0, "R9 cleared", d, 0);
    pulse(7'h28);
    chk(req == 1'b0, "R4 disabled sources", 32'(req), 0);
    bread(A_FLAG, d); chk(d == 32'h28, "R9 set", d, 32'h28);
    bwrite(A_FLAG, 32'h08);
    bread(A_FLAG, d); chk(d == 32'h08, "R9 keep ones", d, 32'h08);
    bwrite(A_FLAG, 32'h0);
    bread(A_FLAG, d); chk(d == 0, "R9 clear all", d, 0);

    summary();
  end
endmodule